// File: doc/BRIEF.md
# Two-Channel PCM Soft Mute with Auto Hard Mute

This stage sits in front of a DAC and takes a signed two-channel PCM stream, one sample pair per valid strobe. Each channel has its own mute request. While a channel is unmuted, its input sample goes straight to the output. When its mute is raised, the output first repeats the last sample taken before the mute. It then shrinks toward zero (midscale for two's-complement) by one exponential step per strobe, with a time constant of about 64 samples. Releasing the mute brings the live input back at once, with no fade-in.

A shared counter counts consecutive strobes on which both channels are muted, and it saturates at a limit of 1024. When the counter reaches the limit and the auto-mute enable is high, the block raises a muted status and forces both outputs to exactly zero. The status drops on the strobe on which any channel leaves mute, or on the clock after the enable goes low.

Top module: `softmute_front`

## Requirements
- R1: While reset is asserted, and after reset until the first valid strobe, left_o, right_o, valid_o and muted_o are all 0.
- R2: On the first muted strobe of a channel, its output equals the last input sample that the channel took on an unmuted strobe (0 if there was none since reset).
- R3: On a strobe where a channel's mute is low, that channel's output equals its input sample on that strobe, including full-scale values.
- R4: On each further muted strobe the output is y' = y - (y >>> 6) (arithmetic shift), where y is the previous muted output. A value with -64 < y < 64 steps to exactly 0 instead.
- R5: The all-mute counter advances only on strobes where both mutes are high, saturates at 1024, and clears on any strobe with a mute low. On the strobe that brings it to 1024, or on any later strobe with it saturated, if auto_en_i is high then muted_o goes to 1 and both outputs go to 0.
- R6: Outputs and muted_o update on the clock edge that samples valid_i, and valid_o is valid_i delayed by exactly one clock.
- R7: When auto_en_i is low, muted_o is 0 from the next clock on and no output is forced to zero, whatever the counter value.
- R8: On a strobe where either mute is low, muted_o returns to 0 and the unmuted channel passes its input.
- R9: Each channel follows its own mute. A muted left channel does not change the right channel's pass-through, and a muted right channel does not change the left's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| left_i | input | 24 | Left input sample, signed |
| right_i | input | 24 | Right input sample, signed |
| mute_left_i | input | 1 | Left mute request |
| mute_right_i | input | 1 | Right mute request |
| auto_en_i | input | 1 | Enables the hard mute after a long all-channel mute |
| left_o | output | 24 | Left output sample |
| right_o | output | 24 | Right output sample |
| valid_o | output | 1 | Output strobe, valid_i delayed one clock |
| muted_o | output | 1 | Hard-mute status |

## Verification
Every result in this block arrives one clock after the strobe that caused it: the output samples, valid_o and muted_o are all registered on the edge that samples valid_i. The bench therefore raises the strobe at a falling edge, drops it at the next falling edge, and compares all outputs at that moment against a model that is advanced once per strobe. The clearing of muted_o by the enable is the one case not tied to a strobe. It is due one clock after auto_en_i falls, and the bench samples it at the falling edge that follows.

// File: rtl/softmute_pkg.sv
package softmute_pkg;
  localparam int SAMPLE_W  = 24;
  localparam int NUM_CH    = 2;
  localparam int TAU_SHIFT = 6;
  localparam int MUTE_LIM  = 1024;
endpackage

// File: rtl/softmute_channel.sv
module softmute_channel #(
  parameter int W     = softmute_pkg::SAMPLE_W,
  parameter int SHIFT = softmute_pkg::TAU_SHIFT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                mute_i,
  input  logic                hard_i,
  input  logic signed [W-1:0] sample_i,
  output logic signed [W-1:0] sample_o
);
  localparam logic signed [W-1:0] NEAR_LIM = W'(1 << SHIFT);

  logic signed [W-1:0] hold_q, out_q, step, decayed;
  logic                near_zero;

  assign step      = hold_q >>> SHIFT;
  assign near_zero = (hold_q < NEAR_LIM) && (hold_q > -NEAR_LIM);
  assign decayed   = near_zero ? '0 : hold_q - step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
    end else if (valid_i) begin
      if (!mute_i) begin
        hold_q <= sample_i;
        out_q  <= sample_i;
      end else begin
        hold_q <= decayed;
        out_q  <= hard_i ? '0 : hold_q;
      end
    end
  end

  assign sample_o = out_q;

  function automatic logic [W:0] mag(input logic signed [W-1:0] v);
    return v[W-1] ? ({1'b0, ~v} + 1'b1) : {1'b0, v};
  endfunction

  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mute_i |=> sample_o == $past(sample_i)); // R3
  AST_DECAY_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mute_i |=> mag(hold_q) <= mag($past(hold_q))); // R4
endmodule

// File: rtl/softmute_allmute_ctr.sv
module softmute_allmute_ctr #(
  parameter int LIMIT = softmute_pkg::MUTE_LIM
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic all_mute_i,
  input  logic en_i,
  output logic hard_o,
  output logic muted_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_next;
  logic          muted_q;

  always_comb begin
    if (!all_mute_i)         cnt_next = '0;
    else if (cnt_q == LIM_C) cnt_next = LIM_C;
    else                     cnt_next = cnt_q + 1'b1;
  end

  assign hard_o = valid_i && all_mute_i && en_i && (cnt_next == LIM_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      muted_q <= 1'b0;
    end else begin
      if (valid_i) cnt_q <= cnt_next;
      if (!en_i)        muted_q <= 1'b0;
      else if (valid_i) muted_q <= hard_o;
    end
  end

  assign muted_o = muted_q;

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM_C); // R5
  AST_EN_LOW_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !muted_o); // R7
  AST_RELEASE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !all_mute_i |=> !muted_o); // R8
endmodule

// File: rtl/softmute_front.sv
module softmute_front
  import softmute_pkg::*;
#(
  parameter int W     = SAMPLE_W,
  parameter int SHIFT = TAU_SHIFT,
  parameter int LIMIT = MUTE_LIM
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] left_i,
  input  logic signed [W-1:0] right_i,
  input  logic                mute_left_i,
  input  logic                mute_right_i,
  input  logic                auto_en_i,
  output logic signed [W-1:0] left_o,
  output logic signed [W-1:0] right_o,
  output logic                valid_o,
  output logic                muted_o
);
  logic signed [W-1:0] ch_in  [NUM_CH];
  logic signed [W-1:0] ch_out [NUM_CH];
  logic [NUM_CH-1:0]   ch_mute;
  logic                hard, valid_q;

  assign ch_in[0] = left_i;
  assign ch_in[1] = right_i;
  assign ch_mute  = {mute_right_i, mute_left_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    softmute_channel #(.W(W), .SHIFT(SHIFT)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .mute_i  (ch_mute[c]),
      .hard_i  (hard),
      .sample_i(ch_in[c]),
      .sample_o(ch_out[c])
    );
  end

  softmute_allmute_ctr #(.LIMIT(LIMIT)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .all_mute_i(&ch_mute),
    .en_i      (auto_en_i),
    .hard_o    (hard),
    .muted_o   (muted_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;
  assign left_o  = ch_out[0];
  assign right_o = ch_out[1];

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R6
  AST_HARD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    muted_o |-> (left_o == '0) && (right_o == '0)); // R5
endmodule

// File: tb/softmute_front_tb.sv
module softmute_front_tb_top;
  localparam int W = 24;
  localparam int LIM = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, ml = 1'b0, mr = 1'b0, en = 1'b0;
  logic signed [W-1:0] li = '0, ri = '0;
  logic signed [W-1:0] lo, ro;
  logic vo, muted;

  int errs = 0, checks = 0;
  logic signed [W-1:0] h_l = '0, h_r = '0, e_l = '0, e_r = '0;
  logic pm_l = 1'b0, pm_r = 1'b0, e_m = 1'b0;
  int cnt = 0;

  always #2 clk = ~clk;

  softmute_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .left_i(li), .right_i(ri),
    .mute_left_i(ml), .mute_right_i(mr), .auto_en_i(en),
    .left_o(lo), .right_o(ro), .valid_o(vo), .muted_o(muted)
  );

  function automatic logic signed [W-1:0] decay(input logic signed [W-1:0] y);
    if (y > -64 && y < 64) return '0;
    return y - (y >>> 6);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe(input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                        input logic m_l, input logic m_r);
    string tl, tr;
    logic hm;
    @(negedge clk);
    li = l; ri = r; ml = m_l; mr = m_r; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    tl = !m_l ? (m_r ? "R9" : "R3") : (!pm_l ? "R2" : "R4");
    tr = !m_r ? (m_l ? "R9" : "R3") : (!pm_r ? "R2" : "R4");
    if (!m_l) begin e_l = l; h_l = l; end else begin e_l = h_l; h_l = decay(h_l); end
    if (!m_r) begin e_r = r; h_r = r; end else begin e_r = h_r; h_r = decay(h_r); end
    pm_l = m_l; pm_r = m_r;
    if (m_l && m_r) cnt = (cnt == LIM) ? LIM : cnt + 1; else cnt = 0;
    hm = en && m_l && m_r && cnt == LIM;
    if (hm) begin e_l = '0; e_r = '0; tl = "R5"; tr = "R5"; end
    e_m = hm;
    chk(tl, lo, e_l);
    chk(tr, ro, e_r);
    chk((m_l && m_r) ? "R5" : "R8", muted, e_m);
    chk("R6", vo, 1);
    @(negedge clk);
    chk("R6", vo, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1", lo, 0); chk("R1", ro, 0); chk("R1", vo, 0); chk("R1", muted, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", lo, 0); chk("R1", muted, 0);

    // mute from reset: held value is zero
    strobe(24'sd5, 24'sd7, 1'b1, 1'b0);
    // full-scale pass-through
    strobe(24'sh7fffff, 24'sh800000, 1'b0, 1'b0);
    // left mute from max, right keeps passing
    for (int i = 0; i < 12; i++) strobe(W'($urandom), W'($urandom), 1'b1, 1'b0);
    strobe(24'sh800000, -24'sd70, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) strobe(W'($urandom), W'($urandom), 1'b0, 1'b1);
    // small tails snap to zero
    strobe(24'sd100, -24'sd70, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) strobe(24'sd1, 24'sd1, 1'b1, 1'b1);
    strobe(-24'sd64, 24'sd64, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) strobe(24'sd1, 24'sd1, 1'b1, 1'b1);

    // auto hard mute reached, saturated, then released by one channel
    en = 1'b1;
    strobe(24'sd3000000, -24'sd3000000, 1'b0, 1'b0);
    for (int i = 0; i < LIM + 6; i++) strobe(W'($urandom), W'($urandom), 1'b1, 1'b1);
    strobe(24'sd1234, 24'sd99, 1'b1, 1'b0);
    for (int i = 0; i < LIM + 2; i++) strobe(W'($urandom), W'($urandom), 1'b1, 1'b1);
    // enable dropped while hard-muted
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R7", muted, 0);
    chk("R7", lo, 0);
    for (int i = 0; i < 3; i++) strobe(W'($urandom), W'($urandom), 1'b1, 1'b1);
    en = 1'b1;
    strobe(W'($urandom), W'($urandom), 1'b1, 1'b1);
    strobe(24'sd42, -24'sd42, 1'b0, 1'b1);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int gap;
      gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      if ($urandom_range(0, 40) == 0) en = ~en;
      strobe(W'($urandom), W'($urandom), $urandom_range(0, 3) != 0,
             $urandom_range(0, 3) != 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule